// File: doc/BRIEF.md
# Dual-Master RAM Write-Protection Filter

This block sits between two bus masters (a main CPU and a coprocessor CPU) and two shared memories: a small on-chip work RAM and a larger battery-backed RAM. Each access request carries a master identifier, a 24-bit address, a write flag and a data byte. Reads always go through to the addressed memory. A write reaches memory only when the issuing master's protection settings allow it. Otherwise it is dropped silently: no strobe is raised, no error is reported, and the memory keeps its contents.

The work RAM is split into 256-byte pages. Each master has its own page-enable mask. The masks are all zero after reset, so the work RAM starts write-locked for both masters. A page is unlocked by writing 1 to its enable bit. The backup RAM has a protected window at offset 0. The window size is 256 bytes shifted left by a shared 4-bit code. Each master also has one backup-RAM enable bit. When that bit is set, the master may write anywhere in the backup RAM. When it is clear, the master's writes inside the window are dropped and its writes outside the window still land.

Requests arrive as a valid-qualified beat with no ready signal. The filter never applies back-pressure and accepts a beat in every cycle. Configuration writes use a separate plain port.

Top module: `wp_write_filter`

## Requirements
- R1: After reset, all page-enable masks, both backup-RAM enables and the window code are 0, so every write to work RAM is dropped until an enable bit is set.
- R2: A write by master m to work RAM page p (address bits [10:8], work RAM at 0x003000..0x0037FF) raises `iram_we` only when bit p of master m's mask is 1. Writing a 0 to a mask bit locks the page again.
- R3: A dropped write raises no strobe at all on either memory.
- R4: The two masters' settings are independent. Unlocking a page or the backup RAM for one master does not unlock it for the other (master 0 = main, master 1 = coprocessor).
- R5: With master m's backup-RAM enable clear, its writes at backup RAM offsets below 256 << code are dropped (backup RAM at 0x400000..0x41FFFF). For example, code 2 protects 0x000..0x3FF.
- R6: With master m's backup-RAM enable clear, its writes at offsets at or above the window size still raise `bram_we`.
- R7: With master m's backup-RAM enable set, every backup RAM offset is writable by m, whatever the code.
- R8: Reads to either memory always raise the matching read strobe, whatever the protection settings.
- R9: Results are due in the cycle after the request is sampled, with the offset and data on `mem_off` and `mem_wdata`. At most one strobe is active at a time, and an address outside both memories raises none.
- R10: Configuration write encoding on `cfg_sel`: 0 loads `cfg_wdata[7:0]` into the mask of master `cfg_mst`, 1 loads `cfg_wdata[0]` into that master's backup-RAM enable, and 2 loads `cfg_wdata[3:0]` into the shared window code. A configuration write at the same edge as a request already governs that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request beat present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mst | input | 1 | Issuing master (0 main, 1 coprocessor) |
| req_addr | input | 24 | Request address |
| req_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mst | input | 1 | Master whose registers are written |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 8 | Configuration value |
| iram_we | output | 1 | Work RAM write strobe |
| iram_re | output | 1 | Work RAM read strobe |
| bram_we | output | 1 | Backup RAM write strobe |
| bram_re | output | 1 | Backup RAM read strobe |
| mem_off | output | 17 | Offset within the addressed memory |
| mem_wdata | output | 8 | Write data to memory |

## Verification
Every memory strobe is due exactly one cycle after the edge that samples the request. The bench drives each beat on a falling edge and pushes its expected strobes, offset and data into a queue. A monitor notes the rising edge that takes a valid beat and compares against the head of the queue on the next falling edge. Configuration writes issued together with a request update the bench model before the request's expectation is computed, because the register and the request load at the same edge. Cycles with no sampled beat are checked for all strobes low.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int ADDR_W = 24;
  localparam int NUM_MST = 2;
  localparam int MST_W = $clog2(NUM_MST);

  typedef enum logic [1:0] {
    CFG_PAGE_MASK = 2'd0,
    CFG_BRAM_EN   = 2'd1,
    CFG_WIN_CODE  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/wp_req_reg.sv
module wp_req_reg #(
  parameter int DW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_vld,
  input  logic                         in_wr,
  input  logic [wp_pkg::MST_W-1:0]     in_mst,
  input  logic [wp_pkg::ADDR_W-1:0]    in_addr,
  input  logic [DW-1:0]                in_data,
  output logic                         q_vld,
  output logic                         q_wr,
  output logic [wp_pkg::MST_W-1:0]     q_mst,
  output logic [wp_pkg::ADDR_W-1:0]    q_addr,
  output logic [DW-1:0]                q_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_wr   <= 1'b0;
      q_mst  <= '0;
      q_addr <= '0;
      q_data <= '0;
    end else begin
      q_vld  <= in_vld;
      q_wr   <= in_wr;
      q_mst  <= in_mst;
      q_addr <= in_addr;
      q_data <= in_data;
    end
  end
endmodule

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs #(
  parameter int PAGES  = 8,
  parameter int CODE_W = 4,
  parameter int CFG_W  = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_we,
  input  logic [wp_pkg::MST_W-1:0]                 cfg_mst,
  input  logic [1:0]                               cfg_sel,
  input  logic [CFG_W-1:0]                         cfg_wdata,
  output logic [wp_pkg::NUM_MST-1:0][PAGES-1:0]    page_en,
  output logic [wp_pkg::NUM_MST-1:0]               bram_en,
  output logic [CODE_W-1:0]                        win_code
);
  import wp_pkg::*;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(cfg_sel);

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    logic hit;
    assign hit = cfg_we && (cfg_mst == m[MST_W-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        page_en[m] <= '0;
        bram_en[m] <= 1'b0;
      end else if (hit) begin
        if (sel == CFG_PAGE_MASK) page_en[m] <= cfg_wdata[PAGES-1:0];
        if (sel == CFG_BRAM_EN)   bram_en[m] <= cfg_wdata[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      win_code <= '0;
    else if (cfg_we && sel == CFG_WIN_CODE)
      win_code <= cfg_wdata[CODE_W-1:0];
  end
endmodule

// File: rtl/wp_filter_core.sv
module wp_filter_core #(
  parameter int                    PAGES     = 8,
  parameter int                    CODE_W    = 4,
  parameter int                    BRAM_AW   = 17,
  parameter int                    DW        = 8,
  parameter logic [23:0]           IRAM_BASE = 24'h003000,
  parameter logic [23:0]           BRAM_BASE = 24'h400000,
  localparam int                   IRAM_AW   = $clog2(PAGES) + 8,
  localparam int                   OFF_W     = (IRAM_AW > BRAM_AW) ? IRAM_AW : BRAM_AW
) (
  input  logic                                  q_vld,
  input  logic                                  q_wr,
  input  logic [wp_pkg::MST_W-1:0]              q_mst,
  input  logic [wp_pkg::ADDR_W-1:0]             q_addr,
  input  logic [DW-1:0]                         q_data,
  input  logic [wp_pkg::NUM_MST-1:0][PAGES-1:0] page_en,
  input  logic [wp_pkg::NUM_MST-1:0]            bram_en,
  input  logic [CODE_W-1:0]                     win_code,
  output logic                                  iram_we,
  output logic                                  iram_re,
  output logic                                  bram_we,
  output logic                                  bram_re,
  output logic [OFF_W-1:0]                      mem_off,
  output logic [DW-1:0]                         mem_wdata
);
  logic               in_iram, in_bram;
  logic [PAGES-1:0]   mask;
  logic               page_ok, in_win, bram_ok;
  logic [BRAM_AW-1:0] b_off;

  assign in_iram = (q_addr[23:IRAM_AW] == IRAM_BASE[23:IRAM_AW]);
  assign in_bram = (q_addr[23:BRAM_AW] == BRAM_BASE[23:BRAM_AW]);

  assign mask    = page_en[q_mst];
  assign page_ok = mask[q_addr[IRAM_AW-1:8]];

  assign b_off   = q_addr[BRAM_AW-1:0];
  assign in_win  = ((b_off >> (8 + int'(win_code))) == '0);
  assign bram_ok = bram_en[q_mst] || !in_win;

  always_comb begin
    iram_we = q_vld && in_iram &&  q_wr && page_ok;
    iram_re = q_vld && in_iram && !q_wr;
    bram_we = q_vld && in_bram &&  q_wr && bram_ok;
    bram_re = q_vld && in_bram && !q_wr;
    mem_off = '0;
    if (in_iram) mem_off[IRAM_AW-1:0] = q_addr[IRAM_AW-1:0];
    else         mem_off[BRAM_AW-1:0] = b_off;
    mem_wdata = q_data;
  end
endmodule

// File: rtl/wp_write_filter.sv
module wp_write_filter #(
  parameter int          PAGES     = 8,
  parameter int          CODE_W    = 4,
  parameter int          BRAM_AW   = 17,
  parameter int          DW        = 8,
  parameter logic [23:0] IRAM_BASE = 24'h003000,
  parameter logic [23:0] BRAM_BASE = 24'h400000,
  localparam int         IRAM_AW   = $clog2(PAGES) + 8,
  localparam int         OFF_W     = (IRAM_AW > BRAM_AW) ? IRAM_AW : BRAM_AW,
  localparam int         CFG_W     = (PAGES > CODE_W) ? PAGES : CODE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [wp_pkg::MST_W-1:0]   req_mst,
  input  logic [wp_pkg::ADDR_W-1:0]  req_addr,
  input  logic [DW-1:0]              req_wdata,
  input  logic                       cfg_we,
  input  logic [wp_pkg::MST_W-1:0]   cfg_mst,
  input  logic [1:0]                 cfg_sel,
  input  logic [CFG_W-1:0]           cfg_wdata,
  output logic                       iram_we,
  output logic                       iram_re,
  output logic                       bram_we,
  output logic                       bram_re,
  output logic [OFF_W-1:0]           mem_off,
  output logic [DW-1:0]              mem_wdata
);
  logic                                  q_vld, q_wr;
  logic [wp_pkg::MST_W-1:0]              q_mst;
  logic [wp_pkg::ADDR_W-1:0]             q_addr;
  logic [DW-1:0]                         q_data;
  logic [wp_pkg::NUM_MST-1:0][PAGES-1:0] page_en;
  logic [wp_pkg::NUM_MST-1:0]            bram_en;
  logic [CODE_W-1:0]                     win_code;

  wp_req_reg #(.DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n),
    .in_vld(req_valid), .in_wr(req_write), .in_mst(req_mst),
    .in_addr(req_addr), .in_data(req_wdata),
    .q_vld(q_vld), .q_wr(q_wr), .q_mst(q_mst), .q_addr(q_addr), .q_data(q_data)
  );

  wp_cfg_regs #(.PAGES(PAGES), .CODE_W(CODE_W), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_mst(cfg_mst), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .page_en(page_en), .bram_en(bram_en), .win_code(win_code)
  );

  wp_filter_core #(
    .PAGES(PAGES), .CODE_W(CODE_W), .BRAM_AW(BRAM_AW), .DW(DW),
    .IRAM_BASE(IRAM_BASE), .BRAM_BASE(BRAM_BASE)
  ) u_core (
    .q_vld(q_vld), .q_wr(q_wr), .q_mst(q_mst), .q_addr(q_addr), .q_data(q_data),
    .page_en(page_en), .bram_en(bram_en), .win_code(win_code),
    .iram_we(iram_we), .iram_re(iram_re), .bram_we(bram_we), .bram_re(bram_re),
    .mem_off(mem_off), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/wp_filter_chk.sv
module wp_filter_chk #(
  parameter int          PAGES     = 8,
  parameter int          BRAM_AW   = 17,
  parameter int          OFF_W     = 17,
  parameter int          CFG_W     = 8,
  parameter logic [23:0] IRAM_BASE = 24'h003000,
  parameter logic [23:0] BRAM_BASE = 24'h400000,
  localparam int         IRAM_AW   = $clog2(PAGES) + 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_write,
  input logic [wp_pkg::MST_W-1:0]   req_mst,
  input logic [wp_pkg::ADDR_W-1:0]  req_addr,
  input logic                       cfg_we,
  input logic [wp_pkg::MST_W-1:0]   cfg_mst,
  input logic [1:0]                 cfg_sel,
  input logic [CFG_W-1:0]           cfg_wdata,
  input logic                       iram_we,
  input logic                       iram_re,
  input logic                       bram_we,
  input logic                       bram_re,
  input logic [OFF_W-1:0]           mem_off
);
  logic                         unlock_seen;
  logic [wp_pkg::NUM_MST-1:0]   bram_sh;
  logic                         in_i, in_b;

  assign in_i = (req_addr[23:IRAM_AW] == IRAM_BASE[23:IRAM_AW]);
  assign in_b = (req_addr[23:BRAM_AW] == BRAM_BASE[23:BRAM_AW]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlock_seen <= 1'b0;
      bram_sh     <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == 2'd0 && cfg_wdata[PAGES-1:0] != '0) unlock_seen <= 1'b1;
      if (cfg_sel == 2'd1) bram_sh[cfg_mst] <= cfg_wdata[0];
    end
  end

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({iram_we, iram_re, bram_we, bram_re}));

  // R8
  iram_read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && !req_write && in_i)) |-> iram_re);

  // R8
  bram_read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && !req_write && in_b)) |-> bram_re);

  // R1
  locked_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iram_we |-> unlock_seen);

  // R5
  bram_base_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bram_we && mem_off < OFF_W'(256)) |-> bram_sh[$past(req_mst)]);

  // R9
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid && !in_i && !in_b)) |->
      !(iram_we || iram_re || bram_we || bram_re));
endmodule

bind wp_write_filter wp_filter_chk #(
  .PAGES(PAGES), .BRAM_AW(BRAM_AW), .OFF_W(OFF_W), .CFG_W(CFG_W),
  .IRAM_BASE(IRAM_BASE), .BRAM_BASE(BRAM_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_write(req_write), .req_mst(req_mst), .req_addr(req_addr),
  .cfg_we(cfg_we), .cfg_mst(cfg_mst), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .iram_we(iram_we), .iram_re(iram_re), .bram_we(bram_we), .bram_re(bram_re),
  .mem_off(mem_off)
);

// File: tb/wp_write_filter_tb.sv
module wp_write_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_mst;
  logic [23:0] req_addr;
  logic [7:0]  req_wdata;
  logic        cfg_we, cfg_mst;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        iram_we, iram_re, bram_we, bram_re;
  logic [16:0] mem_off;
  logic [7:0]  mem_wdata;

  always #4 clk = ~clk;

  wp_write_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_mst(req_mst),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cfg_we(cfg_we), .cfg_mst(cfg_mst), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .iram_we(iram_we), .iram_re(iram_re), .bram_we(bram_we), .bram_re(bram_re),
    .mem_off(mem_off), .mem_wdata(mem_wdata)
  );

  typedef struct {
    logic [3:0]  strb;
    logic [16:0] off;
    logic [7:0]  data;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  logic pend = 1'b0;
  bit   done = 1'b0;

  logic [7:0] m_page [2];
  logic       m_bram [2];
  logic [3:0] m_code;

  task automatic cyc();
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b0;
  endtask

  task automatic cfg(input logic mst, input logic [1:0] sel, input logic [7:0] val);
    cfg_we = 1'b1; cfg_mst = mst; cfg_sel = sel; cfg_wdata = val;
    if (sel == 2'd0) m_page[mst] = val;
    if (sel == 2'd1) m_bram[mst] = val[0];
    if (sel == 2'd2) m_code = val[3:0];
  endtask

  task automatic req(input logic wr, input logic mst, input logic [23:0] a,
                     input logic [7:0] d, input string tag);
    exp_t e;
    logic in_i, in_b, win;
    req_valid = 1'b1; req_write = wr; req_mst = mst; req_addr = a; req_wdata = d;
    in_i = (a[23:11] == 13'h0006);
    in_b = (a[23:17] == 7'h20);
    win  = (m_code >= 4'd9) ? 1'b1 : ({15'd0, a[16:0]} < (32'd256 << m_code));
    e.strb = {in_i && wr && m_page[mst][a[10:8]],
              in_i && !wr,
              in_b && wr && (m_bram[mst] || !win),
              in_b && !wr};
    e.off  = in_i ? {6'd0, a[10:0]} : a[16:0];
    e.data = d;
    e.tag  = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) pend <= rst_n && req_valid;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] got;
      got = {iram_we, iram_re, bram_we, bram_re};
      if (pend) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (got != e.strb || (e.strb != 0 && (mem_off != e.off || mem_wdata != e.data))) begin
          n_fail++;
          $display("FAIL %s: strb=%b off=%h data=%h expected strb=%b off=%h data=%h",
                   e.tag, got, mem_off, mem_wdata, e.strb, e.off, e.data);
        end
      end else if (got != 4'b0) begin
        n_run++; n_fail++;
        $display("FAIL R9 idle: strb=%b expected 0000", got);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_mst = 1'b0;
    req_addr = '0; req_wdata = '0; cfg_we = 1'b0; cfg_mst = 1'b0;
    cfg_sel = '0; cfg_wdata = '0;
    m_page[0] = '0; m_page[1] = '0; m_bram[0] = 1'b0; m_bram[1] = 1'b0; m_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if ({iram_we, iram_re, bram_we, bram_re} != 4'b0) begin
      n_fail++;
      $display("FAIL R1 reset: strb=%b expected 0000", {iram_we, iram_re, bram_we, bram_re});
    end
    rst_n = 1'b1;

    // R1 R3: locked work RAM for both masters after reset
    cyc(); req(1, 0, 24'h003000, 8'h11, "R1 m0 page0 locked");
    cyc(); req(1, 1, 24'h0037FF, 8'h12, "R1 m1 page7 locked");
    // R8: reads pass while locked
    cyc(); req(0, 1, 24'h003456, 8'h00, "R8 iram read");
    cyc(); req(0, 0, 24'h400010, 8'h00, "R8 bram read");
    // R2 R4: mask 0x05 for master 0
    cyc(); cfg(0, 2'd0, 8'h05);
    cyc(); req(1, 0, 24'h003010, 8'hA0, "R2 page0 open");
    cyc(); req(1, 0, 24'h003110, 8'hA1, "R2 page1 locked");
    cyc(); req(1, 0, 24'h0032FF, 8'hA2, "R2 page2 open");
    cyc(); req(1, 1, 24'h003010, 8'hA3, "R4 other master locked");
    // R2: clearing a bit relocks
    cyc(); cfg(0, 2'd0, 8'h04);
    cyc(); req(1, 0, 24'h003010, 8'hA4, "R2 page0 relocked");
    // R10: config and request at the same edge
    cyc(); cfg(1, 2'd0, 8'h80); req(1, 1, 24'h003700, 8'hA5, "R10 same-edge mask");
    // R5 R6: window code 2
    cyc(); cfg(0, 2'd2, 8'h02);
    cyc(); req(1, 1, 24'h4003FF, 8'hB0, "R5 code2 top of window");
    cyc(); req(1, 1, 24'h400400, 8'hB1, "R6 code2 above window");
    cyc(); req(1, 0, 24'h400000, 8'hB2, "R5 code2 base");
    // R5 R6: code 0
    cyc(); cfg(1, 2'd2, 8'h00);
    cyc(); req(1, 0, 24'h4000FF, 8'hB3, "R5 code0 inside");
    cyc(); req(1, 0, 24'h400100, 8'hB4, "R6 code0 outside");
    // R5: code 15 covers all of backup RAM
    cyc(); cfg(0, 2'd2, 8'h0F);
    cyc(); req(1, 1, 24'h41FFFF, 8'hB5, "R5 code15 top");
    // R7 R4: enable for master 1 only
    cyc(); cfg(1, 2'd1, 8'h01);
    cyc(); req(1, 1, 24'h400000, 8'hC0, "R7 m1 enabled base");
    cyc(); req(1, 1, 24'h41FFFF, 8'hC1, "R7 m1 enabled top");
    cyc(); req(1, 0, 24'h400000, 8'hC2, "R4 m0 still protected");
    // R10: same-edge backup enable clear
    cyc(); cfg(1, 2'd1, 8'h00); req(1, 1, 24'h400020, 8'hC3, "R10 same-edge bram en");
    // R9: unmapped addresses
    cyc(); req(1, 0, 24'h003800, 8'hD0, "R9 above work RAM");
    cyc(); req(0, 1, 24'h420000, 8'hD1, "R9 above backup RAM");
    cyc(); req(1, 1, 24'h002FFF, 8'hD2, "R9 below work RAM");
    cyc(); cyc(); cyc();
    finish_run();
  end
endmodule